// File: doc/BRIEF.md
# Interrupt Status and Clear Register Unit

This unit gathers the event signals of a two-wire serial bus controller into twelve raw status bits and turns them into a single interrupt request. Ten of the events are short pulses and are held in sticky bits until software clears them. Two events, receive-above-threshold and transmit-below-threshold, are levels that the raw bits simply follow. A mask register chooses which raw bits reach the interrupt line. A masked view of the status can be read at its own address.

Software clears a sticky bit by reading that bit's own clear address. One clear read touches only its own bit, so an event that arrives while the handler is busy with another source is not lost. A combined clear address clears every sticky bit at once. When the transmit-abort event fires, the unit also captures a cause word from the core. That word is cleared by the same read that clears the abort bit, so software has to read the cause word first.

The register port is a plain single-cycle read/write port. Read data is valid in the same cycle as the read strobe. A clear takes effect at the clock edge that ends the read.

Top module: `irq_status_unit`

## Requirements
- R1: After a synchronous active-low reset, the raw status, the mask, the abort cause word and `irq_o` are all zero.
- R2: A one-cycle pulse on `evt_in` bit i, for a sticky source, sets raw bit i at the next clock edge, and the bit then stays set until it is cleared. The bit positions are: 0 receive underflow, 1 receive overflow, 3 transmit overflow, 5 read request, 6 transmit abort, 7 receive done, 8 activity, 9 stop seen, 10 start seen, 11 general call.
- R3: Raw bit 2 (receive above threshold) and raw bit 4 (transmit below threshold) copy `evt_in[2]` and `evt_in[4]` one cycle later. No clear read changes them, including the combined clear.
- R4: The mask is written at address 0x04 from the 12 bits of `reg_wdata` and reads back at 0x04. The raw status reads at 0x08 and the masked status reads at 0x00. The masked status equals raw AND mask. All of these use bits 11:0.
- R5: `irq_o` is high exactly when at least one bit of raw AND mask is set.
- R6: A read of address 0x44 + 4*k clears only the k-th sticky source, taken in ascending bit order 0,1,3,5,6,7,8,9,10,11, so that 0x44 is bit 0 and 0x68 is bit 11. The read returns the bit's value before the clear in data bit 0.
- R7: A read of address 0x40 clears every sticky bit and the abort cause word, and returns zero.
- R8: If a pulse arrives in the same cycle as a clear read of its bit, whether per-source or combined, the bit is set after that edge.
- R9: A pulse on bit 6 ORs `abort_cause` into the cause word, which reads at 0x0C. A read of 0x54 or 0x40 clears the word. If an abort pulse arrives in the same cycle as such a read, the word becomes exactly the new cause.
- R10: Writes to any address other than 0x04 change nothing. A read of any unmapped address, or any cycle without `reg_rd`, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 12 | Event inputs: pulses on sticky bits, levels on bits 2 and 4 |
| abort_cause | input | ABRT_W (16) | Abort cause word, sampled with the bit 6 pulse |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | ADDR_W (8) | Byte address |
| reg_wdata | input | 12 | Write data (mask bits) |
| reg_rdata | output | DATA_W (32) | Read data, valid while reg_rd is high |
| irq_o | output | 1 | Interrupt request |

## Verification
A raw bit that is wrongly set or wrongly lost shows up on `irq_o` in the cycle after the faulty edge, provided the mask selects that bit. Otherwise it shows up on the next read of the raw or masked status. A clear decode that hits a neighbouring bit is exposed by reading the raw status right after each per-source clear. Same-cycle races between a pulse and a clear, and between an abort and its cause-word clear, are driven on purpose. They are judged by the very next status or cause-word read.

// File: rtl/irq_regs_pkg.sv
// Shared constants of the interrupt status unit: source bit positions,
// register addresses and the clear-address map.
// Assumes twelve sources and 32-bit aligned addresses.
package irq_regs_pkg;

    localparam int NSRC = 12;

    localparam int SRC_RX_UNDER  = 0;
    localparam int SRC_RX_OVER   = 1;
    localparam int SRC_RX_THRESH = 2;
    localparam int SRC_TX_OVER   = 3;
    localparam int SRC_TX_THRESH = 4;
    localparam int SRC_RD_REQ    = 5;
    localparam int SRC_TX_ABORT  = 6;
    localparam int SRC_RX_DONE   = 7;
    localparam int SRC_ACTIVITY  = 8;
    localparam int SRC_STOP_SEEN = 9;
    localparam int SRC_STRT_SEEN = 10;
    localparam int SRC_GEN_CALL  = 11;

    // Sources that follow a level instead of latching a pulse.
    localparam logic [NSRC-1:0] LEVEL_SRC = (NSRC'(1) << SRC_RX_THRESH) |
                                            (NSRC'(1) << SRC_TX_THRESH);

    localparam int A_MSTAT    = 'h00;
    localparam int A_MASK     = 'h04;
    localparam int A_RAW      = 'h08;
    localparam int A_CAUSE    = 'h0C;
    localparam int A_CLR_ALL  = 'h40;
    localparam int A_CLR_BASE = 'h44;

    // Per-source clear address: sticky sources in ascending order, skipping levels.
    function automatic int clr_addr(input int src);
        int slot;
        slot = src;
        if (src > SRC_RX_THRESH) slot = slot - 1;
        if (src > SRC_TX_THRESH) slot = slot - 1;
        return A_CLR_BASE + 4 * slot;
    endfunction

endpackage

// File: rtl/irq_clear_decode.sv
// Decodes a register read into per-source clear strobes.
// Assumes reads are single-cycle strobes; level sources never get a strobe.
module irq_clear_decode
    import irq_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NSRC-1:0]   clr_vec,
    output logic              clr_cause
);

    logic hit_all;
    assign hit_all = rd_en && (addr == ADDR_W'(A_CLR_ALL));

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_dec
            if (LEVEL_SRC[gi]) begin : g_level
                // Level sources have no clear address.
                assign clr_vec[gi] = 1'b0;
            end else begin : g_sticky
                // Own address or the combined address clears this source.
                assign clr_vec[gi] = hit_all ||
                                     (rd_en && (addr == ADDR_W'(clr_addr(gi))));
            end
        end
    endgenerate

    assign clr_cause = clr_vec[SRC_TX_ABORT];

    // R6: a per-source clear read touches at most one source
    p_single_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != ADDR_W'(A_CLR_ALL)) |-> $onehot0(clr_vec));

    // R3: level sources never receive a clear strobe
    p_level_unclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec & LEVEL_SRC) == '0);

endmodule

// File: rtl/irq_event_bank.sv
// Holds the raw status bits: sticky bits latch pulses until cleared,
// level bits follow their input. Assumes clear strobes are one cycle wide.
module irq_event_bank
    import irq_regs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_in,
    input  logic [NSRC-1:0] clr_vec,
    output logic [NSRC-1:0] raw_q
);

    // Update every raw bit; a pulse wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            for (int i = 0; i < NSRC; i++) begin
                raw_q[i] <= LEVEL_SRC[i] ? evt_in[i]
                                         : (evt_in[i] | (raw_q[i] & ~clr_vec[i]));
            end
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_chk
            if (LEVEL_SRC[gi]) begin : g_level
                // R3: level bit copies its input one cycle later
                p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    1'b1 |=> (raw_q[gi] == $past(evt_in[gi])));
            end else begin : g_sticky
                // R2: a pulse sets the bit
                p_pulse_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
                    evt_in[gi] |=> raw_q[gi]);
                // R2: a set bit holds without a clear
                p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
                    (raw_q[gi] && !clr_vec[gi]) |=> raw_q[gi]);
                // R8: pulse and clear together leave the bit set
                p_pulse_beats_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
                    (evt_in[gi] && clr_vec[gi]) |=> raw_q[gi]);
                // R6: a clear without a pulse drops the bit
                p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
                    (clr_vec[gi] && !evt_in[gi]) |=> !raw_q[gi]);
            end
        end
    endgenerate

endmodule

// File: rtl/irq_abort_capture.sv
// Captures the abort cause word on each abort pulse, ORing successive causes.
// Cleared together with the abort status bit. Assumes one-cycle strobes.
module irq_abort_capture #(
    parameter int ABRT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_evt,
    input  logic [ABRT_W-1:0] cause_in,
    input  logic              clr,
    output logic [ABRT_W-1:0] cause_q
);

    // Accumulate causes; a clear empties the word before a new cause is merged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else begin
            cause_q <= (clr ? '0 : cause_q) | (abort_evt ? cause_in : '0);
        end
    end

    // R9: a clear without a new abort empties the word
    p_cause_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !abort_evt) |=> (cause_q == '0));

    // R9: every captured cause bit is present after the pulse
    p_cause_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_evt |=> ((cause_q & $past(cause_in)) == $past(cause_in)));

endmodule

// File: rtl/irq_status_unit.sv
// Interrupt register unit of a serial bus controller: raw and masked status,
// mask register, per-source clear-on-read, combined clear, abort cause capture.
// Assumes a single-cycle register port with combinational read data.
module irq_status_unit
    import irq_regs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int ABRT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt_in,
    input  logic [ABRT_W-1:0] abort_cause,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NSRC-1:0]   reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);

    logic [NSRC-1:0]   clr_vec;
    logic              clr_cause;
    logic [NSRC-1:0]   raw_q;
    logic [NSRC-1:0]   mask_q;
    logic [ABRT_W-1:0] cause_q;
    logic              mask_we;

    irq_clear_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (reg_rd),
        .addr      (reg_addr),
        .clr_vec   (clr_vec),
        .clr_cause (clr_cause)
    );

    irq_event_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_in  (evt_in),
        .clr_vec (clr_vec),
        .raw_q   (raw_q)
    );

    irq_abort_capture #(.ABRT_W(ABRT_W)) u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort_evt (evt_in[SRC_TX_ABORT]),
        .cause_in  (abort_cause),
        .clr       (clr_cause),
        .cause_q   (cause_q)
    );

    assign mask_we = reg_wr && (reg_addr == ADDR_W'(A_MASK));

    // Mask register, written only at its own address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= reg_wdata;
        end
    end

    // Read multiplexer; zero when idle or unmapped.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (reg_addr == ADDR_W'(A_MSTAT)) reg_rdata[NSRC-1:0]   = raw_q & mask_q;
            if (reg_addr == ADDR_W'(A_MASK))  reg_rdata[NSRC-1:0]   = mask_q;
            if (reg_addr == ADDR_W'(A_RAW))   reg_rdata[NSRC-1:0]   = raw_q;
            if (reg_addr == ADDR_W'(A_CAUSE)) reg_rdata[ABRT_W-1:0] = cause_q;
            for (int i = 0; i < NSRC; i++) begin
                if (!LEVEL_SRC[i] && reg_addr == ADDR_W'(clr_addr(i))) reg_rdata[0] = raw_q[i];
            end
        end
    end

    // Interrupt request from the masked sources.
    assign irq_o = |(raw_q & mask_q);

    // R4: a mask write lands at the next edge
    p_mask_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(reg_wdata)));

    // R10: the mask holds without a write to its address
    p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q));

    // R5: no interrupt while the mask is empty
    p_irq_needs_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o);

    // R10: idle port drives zero
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> (reg_rdata == '0));

endmodule

// File: tb/sim_irq_status_unit.sv
module sim_irq_status_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] evt_in;
    logic [15:0] abort_cause;
    logic        reg_rd, reg_wr;
    logic [7:0]  reg_addr;
    logic [11:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .abort_cause(abort_cause),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    int checks = 0;
    int errors = 0;
    int lvl_bits = 0;

    // Behavioural reference state
    bit m_raw[12];
    int m_mask = 0;
    int m_cause = 0;
    int order[10] = '{0, 1, 3, 5, 6, 7, 8, 9, 10, 11};

    function automatic bit is_lvl(int i);
        return (i == 2) || (i == 4);
    endfunction

    function automatic int raw_word();
        int w = 0;
        for (int i = 0; i < 12; i++) if (m_raw[i]) w |= (1 << i);
        return w;
    endfunction

    function automatic int exp_rdata(int a);
        if (a == 'h00) return raw_word() & m_mask;
        if (a == 'h04) return m_mask;
        if (a == 'h08) return raw_word();
        if (a == 'h0C) return m_cause;
        for (int k = 0; k < 10; k++) if (a == 'h44 + 4*k) return int'(m_raw[order[k]]);
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock: drive, compare outputs, advance the model.
    task automatic cyc(bit rd, bit wr, int addr, int wd, int evt, int cause, string tag);
        bit clr[12];
        bit clr_c;
        reg_rd = rd; reg_wr = wr; reg_addr = 8'(addr); reg_wdata = 12'(wd);
        evt_in = 12'(evt | lvl_bits); abort_cause = 16'(cause);
        #1;
        if (rd) check(tag, int'(reg_rdata), exp_rdata(addr), $sformatf("read 0x%0h", addr));
        check("R5", int'(irq_o), int'((raw_word() & m_mask) != 0), "irq_o");
        @(posedge clk);
        for (int i = 0; i < 12; i++) clr[i] = 1'b0;
        if (rd && addr == 'h40) begin
            for (int i = 0; i < 12; i++) clr[i] = !is_lvl(i);
        end else if (rd) begin
            for (int k = 0; k < 10; k++) if (addr == 'h44 + 4*k) clr[order[k]] = 1'b1;
        end
        clr_c = clr[6];
        for (int i = 0; i < 12; i++) begin
            if (is_lvl(i)) m_raw[i] = ((evt | lvl_bits) >> i) & 1;
            else if ((evt >> i) & 1) m_raw[i] = 1'b1;
            else if (clr[i]) m_raw[i] = 1'b0;
        end
        if (clr_c) m_cause = 0;
        if ((evt >> 6) & 1) m_cause |= cause;
        if (wr && addr == 'h04) m_mask = wd & 'hFFF;
        @(negedge clk);
    endtask

    task automatic rd(int addr, string tag);
        cyc(1'b1, 1'b0, addr, 0, 0, 0, tag);
    endtask

    task automatic wr(int addr, int data, string tag);
        cyc(1'b0, 1'b1, addr, data, 0, 0, tag);
    endtask

    task automatic pulse(int evt, int cause, string tag);
        cyc(1'b0, 1'b0, 0, 0, evt, cause, tag);
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        evt_in = 0; abort_cause = 0;
        for (int i = 0; i < 12; i++) m_raw[i] = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", int'(irq_o), 0, "irq_o in reset");
        rst_n = 1'b1;

        // R1: reset state
        rd('h00, "R1"); rd('h04, "R1"); rd('h08, "R1"); rd('h0C, "R1");

        // R2: each sticky source latches a pulse
        for (int i = 0; i < 12; i++) begin
            if (!is_lvl(i)) begin
                pulse(1 << i, 0, "R2");
                rd('h08, "R2");
            end
        end
        pulse(0, 0, "R2");
        rd('h08, "R2");
        rd('h00, "R4");

        // R4/R5: mask patterns and interrupt line
        wr('h04, 'h001, "R4"); rd('h04, "R4"); rd('h00, "R4");
        wr('h04, 'h000, "R5"); pulse(0, 0, "R5");
        wr('h04, 'hA5A, "R4"); rd('h00, "R4");
        wr('h04, 'hFFF, "R4"); rd('h04, "R4"); rd('h00, "R4");

        // R6: per-source clears, one at a time
        for (int k = 0; k < 10; k++) begin
            rd('h44 + 4*k, "R6");
            rd('h08, "R6");
        end
        rd('h44, "R6");

        // R3: level sources follow inputs and ignore clears
        lvl_bits = 'h14;
        pulse(0, 0, "R3");
        rd('h08, "R3");
        rd('h40, "R3");
        rd('h08, "R3");
        lvl_bits = 'h04;
        pulse(0, 0, "R3");
        rd('h08, "R3");
        lvl_bits = 0;
        pulse(0, 0, "R3");
        rd('h08, "R3");

        // R7: combined clear
        pulse('hFEB, 'h0809, "R7");
        rd('h0C, "R7"); rd('h08, "R7");
        rd('h40, "R7");
        rd('h08, "R7"); rd('h0C, "R7");

        // R8: pulse against clear in the same cycle
        cyc(1'b1, 1'b0, 'h60, 0, 1 << 9, 0, "R8");
        rd('h08, "R8");
        cyc(1'b1, 1'b0, 'h40, 0, 1 << 11, 0, "R8");
        rd('h08, "R8");
        rd('h40, "R8");

        // R9: cause word capture and clear
        pulse(1 << 6, 'h0001, "R9");
        pulse(1 << 6, 'h0008, "R9");
        rd('h0C, "R9");
        rd('h54, "R9");
        rd('h0C, "R9"); rd('h08, "R9");
        pulse(1 << 6, 'h0020, "R9");
        cyc(1'b1, 1'b0, 'h54, 0, 1 << 6, 'h0800, "R9");
        rd('h0C, "R9"); rd('h08, "R9");

        // R10: stray writes and unmapped reads
        wr('h08, 'hFFF, "R10"); wr('h00, 'h000, "R10"); wr('h44, 'h000, "R10");
        rd('h08, "R10"); rd('h04, "R10");
        rd('h20, "R10"); rd('h6C, "R10"); rd('h41, "R10");
        wr('h04, 'h200, "R10"); rd('h40, "R10");
        pulse(1 << 9, 0, "R5"); rd('h00, "R5");
        rd('h60, "R5"); pulse(0, 0, "R5");

        finish_run();
    end
endmodule